// File: doc/BRIEF.md
# Tuning Word Source Select and Frequency Clamp

This block produces the frequency tuning word for a direct digital synthesizer's phase accumulator. On each accepted update it selects one of three candidate words according to the loop's operating mode. In free-run mode it uses a stored word. In closed-loop mode it uses the live loop-filter word. In holdover mode it uses the averaged word from the history unit. The selected word is then saturated between a programmable lower and upper frequency bound. The result, with a flag that shows whether saturation took place, is registered into a one-entry output stage.

The bounds are 24-bit values. Each one is placed in the top 24 bits of the 48-bit word, with the lower bits at zero. The block holds both bounds in internal registers, which a one-cycle load strobe writes. Updates enter through a valid/ready handshake. The upstream side may present an update only while `upd_ready` is high. The output stage holds its word until the consumer accepts it, so back-pressure on `out_ready` stalls new updates. The mode code and the candidate words are sampled only in the cycle an update is accepted.

Top module: `tws_clamp_top`

## Requirements
- R1: With mode code 2'b00 the selected word is `free_word`. The reserved code 2'b11 selects `free_word` as well.
- R2: With mode code 2'b01 the selected word is `loop_word` as sampled at each accepted update, so successive updates follow its changes.
- R3: With mode code 2'b10 the selected word is `hist_word`.
- R4: The lower bound N_lo maps to the 48-bit value {N_lo, 24'h0}. The upper bound N_hi maps to {N_hi, 24'h0}, except that N_hi = 24'hFFFFFF maps to 48'hFFFF_FFFF_FFFF. A selected word above the upper value is output as the upper value, and a word below the lower value is output as the lower value. In both cases `clamp_act` is 1.
- R5: A selected word inside the bounds, including one exactly equal to either bound value, is output unchanged with `clamp_act` 0.
- R6: If the lower bound value exceeds the upper bound value, the output is the lower bound value for every selected word. `clamp_act` is 1 unless the selected word equals that value.
- R7: After reset the lower bound is 24'h000000 and the upper bound is 24'hFFFFFF, so every word, including 48'hFFFF_FFFF_FFFF and 0, passes unclamped. After reset `out_valid` is 0 and `upd_ready` is 1.
- R8: A cycle with `lim_wr` high loads both bounds from `lim_lo_in` and `lim_hi_in`. The new bounds apply to updates accepted in later cycles.
- R9: An update is accepted at a clock edge where `upd_valid` and `upd_ready` are both high, and its result appears on the outputs after that edge with `out_valid` high. `upd_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_word`, `clamp_act` and `out_valid` hold.
- R10: The clamp applies in every mode, including free-run and holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode: 00 free-run, 01 closed-loop, 10 holdover, 11 treated as free-run |
| free_word | input | 48 | Stored free-running tuning word |
| loop_word | input | 48 | Loop filter output word |
| hist_word | input | 48 | History unit averaged word |
| lim_wr | input | 1 | Load strobe for both bound registers |
| lim_lo_in | input | 24 | Lower bound value to load |
| lim_hi_in | input | 24 | Upper bound value to load |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Block can accept an update |
| out_word | output | 48 | Clamped tuning word |
| clamp_act | output | 1 | Saturation occurred for `out_word` |
| out_valid | output | 1 | Output stage holds a result |
| out_ready | input | 1 | Consumer accepts the output |

## Verification
A wrong source select shows up at the ports on the first output after an update in the affected mode. A wrong bound expansion shows up the same way, as a word that differs from its expected value by a whole 2^24 step or by the low 24 bits at the all-ones upper bound. A corrupted bound register stays hidden until a selected word lies between the correct and the wrong bound value, so the bench places words exactly on, just above and just below each bound. A flaw in the output stage appears during the first stall, as a word that changes or is lost while `out_ready` is low.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOOP = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_RSVD = 2'b11
  } tws_mode_e;
endpackage

// File: rtl/tws_src_mux.sv
module tws_src_mux #(
  parameter int WORD_W = 48
) (
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] free_word,
  input  logic [WORD_W-1:0] loop_word,
  input  logic [WORD_W-1:0] hist_word,
  output logic [WORD_W-1:0] sel_word
);
  import tws_pkg::*;

  always_comb begin
    unique case (tws_mode_e'(mode))
      MODE_LOOP: sel_word = loop_word;
      MODE_HOLD: sel_word = hist_word;
      default:   sel_word = free_word;  // free-run and reserved code
    endcase
  end
endmodule

// File: rtl/tws_bound_reg.sv
module tws_bound_reg #(
  parameter int LIM_W    = 24,
  parameter bit RST_ONES = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LIM_W-1:0] din,
  output logic [LIM_W-1:0] q
);
  localparam logic [LIM_W-1:0] RST_VAL = RST_ONES ? {LIM_W{1'b1}} : {LIM_W{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/tws_bound_expand.sv
module tws_bound_expand #(
  parameter int LIM_W    = 24,
  parameter int WORD_W   = 48,
  parameter bit IS_UPPER = 1'b0
) (
  input  logic [LIM_W-1:0]  lim,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - LIM_W;

  generate
    if (IS_UPPER) begin : g_upper
      // all-ones limit reaches true full scale
      always_comb word = (&lim) ? {WORD_W{1'b1}} : {lim, {PAD_W{1'b0}}};
    end else begin : g_lower
      always_comb word = {lim, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/tws_saturate.sv
module tws_saturate #(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output logic [WORD_W-1:0] word_out,
  output logic              clamped
);
  logic [WORD_W-1:0] capped;

  always_comb begin
    capped   = (word_in > hi_word) ? hi_word : word_in;
    word_out = (capped < lo_word) ? lo_word : capped;  // lower applied last wins
    clamped  = (word_out != word_in);
  end

  assert_lo_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_word > hi_word) |-> (word_out == lo_word));

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_word <= hi_word) |-> (word_out >= lo_word && word_out <= hi_word));

  assert_pass_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_in >= lo_word && word_in <= hi_word) |-> (word_out == word_in && !clamped));
endmodule

// File: rtl/tws_clamp_top.sv
module tws_clamp_top #(
  parameter int WORD_W = 48,
  parameter int LIM_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] free_word,
  input  logic [WORD_W-1:0] loop_word,
  input  logic [WORD_W-1:0] hist_word,
  input  logic              lim_wr,
  input  logic [LIM_W-1:0]  lim_lo_in,
  input  logic [LIM_W-1:0]  lim_hi_in,
  input  logic              upd_valid,
  output logic              upd_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              clamp_act,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [LIM_W-1:0]  lo_q, hi_q;
  logic [WORD_W-1:0] lo_w, hi_w, sel_w, sat_w;
  logic              sat_c, accept;

  tws_bound_reg #(.LIM_W(LIM_W), .RST_ONES(1'b0)) u_lo_reg (
    .clk(clk), .rst_n(rst_n), .wr(lim_wr), .din(lim_lo_in), .q(lo_q));
  tws_bound_reg #(.LIM_W(LIM_W), .RST_ONES(1'b1)) u_hi_reg (
    .clk(clk), .rst_n(rst_n), .wr(lim_wr), .din(lim_hi_in), .q(hi_q));

  tws_bound_expand #(.LIM_W(LIM_W), .WORD_W(WORD_W), .IS_UPPER(1'b0)) u_lo_exp (
    .lim(lo_q), .word(lo_w));
  tws_bound_expand #(.LIM_W(LIM_W), .WORD_W(WORD_W), .IS_UPPER(1'b1)) u_hi_exp (
    .lim(hi_q), .word(hi_w));

  tws_src_mux #(.WORD_W(WORD_W)) u_mux (
    .mode(mode), .free_word(free_word), .loop_word(loop_word),
    .hist_word(hist_word), .sel_word(sel_w));

  tws_saturate #(.WORD_W(WORD_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .word_in(sel_w), .lo_word(lo_w), .hi_word(hi_w),
    .word_out(sat_w), .clamped(sat_c));

  assign upd_ready = !out_valid || out_ready;
  assign accept    = upd_valid && upd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      clamp_act <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_word  <= sat_w;
      clamp_act <= sat_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(clamp_act)));

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> out_valid);

  assert_bound_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> (lo_q == $past(lim_lo_in) && hi_q == $past(lim_hi_in)));
endmodule

// File: tb/tb_tws_clamp_top.sv
module tb_tws_clamp_top;
  localparam int W = 48;
  localparam int L = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] free_word = '0, loop_word = '0, hist_word = '0;
  logic lim_wr = 1'b0;
  logic [L-1:0] lim_lo_in = '0, lim_hi_in = '0;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [W-1:0] out_word;
  logic clamp_act, out_valid;
  logic out_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [L-1:0] lo_m = 24'h000000;
  logic [L-1:0] hi_m = 24'hFFFFFF;

  typedef struct {
    logic [W-1:0] word;
    logic         clamp;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  tws_clamp_top dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .free_word(free_word),
    .loop_word(loop_word), .hist_word(hist_word), .lim_wr(lim_wr),
    .lim_lo_in(lim_lo_in), .lim_hi_in(lim_hi_in), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .out_word(out_word), .clamp_act(clamp_act),
    .out_valid(out_valid), .out_ready(out_ready));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] m, input logic [W-1:0] fw,
                                 input logic [W-1:0] lw, input logic [W-1:0] hw,
                                 input string tag);
    exp_t e;
    logic [W-1:0] s, lo, hi, r;
    s  = (m == 2'b01) ? lw : (m == 2'b10) ? hw : fw;
    lo = {lo_m, 24'h0};
    hi = (hi_m == 24'hFFFFFF) ? {W{1'b1}} : {hi_m, 24'h0};
    r  = s;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    e.word = r; e.clamp = (r != s); e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [1:0] m, input logic [W-1:0] fw,
                      input logic [W-1:0] lw, input logic [W-1:0] hw, input string tag);
    @(negedge clk); #3;
    mode = m; free_word = fw; loop_word = lw; hist_word = hw; upd_valid = 1'b1;
    while (!upd_ready) begin @(negedge clk); #3; end
    sb.push_back(model(m, fw, lw, hw, tag));
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic load(input logic [L-1:0] lo, input logic [L-1:0] hi);
    @(negedge clk); #3;
    lim_lo_in = lo; lim_hi_in = hi; lim_wr = 1'b1;
    @(posedge clk); #1;
    lim_wr = 1'b0;
    lo_m = lo; hi_m = hi;
  endtask

  // monitor: sets back-pressure, then pops and compares on each transfer
  initial begin
    int cyc = 0;
    bit stalled = 0;
    logic [W-1:0] held_w = '0;
    logic held_c = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (stalled) begin
          check(out_valid && out_word == held_w && clamp_act == held_c, "R9",
                "held output", out_word, held_w);
        end
        #1;
        cyc++;
        out_ready = (cyc % 4 != 3);
        #1;
        stalled = out_valid && !out_ready;
        held_w = out_word; held_c = clamp_act;
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R9", "unexpected output", out_word, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_word == e.word, e.tag, "word", out_word, e.word);
            check(clamp_act == e.clamp, e.tag, "clamp_act",
                  {{(W-1){1'b0}}, clamp_act}, {{(W-1){1'b0}}, e.clamp});
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R7", "out_valid after reset", {{(W-1){1'b0}}, out_valid}, '0);
    check(upd_ready, "R7", "upd_ready after reset", {{(W-1){1'b0}}, upd_ready}, 48'd1);
    mon_on = 1;

    // R7: default bounds leave extremes untouched
    send(2'b00, 48'hFFFF_FFFF_FFFF, 48'h1, 48'h2, "R7");
    send(2'b00, 48'h0, 48'h1, 48'h2, "R7");
    // R1, R2, R3: source selection, reserved code as free-run
    send(2'b00, 48'h1111_2222_3333, 48'hAAAA_0000_0001, 48'h5555_0000_0002, "R1");
    send(2'b11, 48'h0123_4567_89AB, 48'hAAAA_0000_0001, 48'h5555_0000_0002, "R1");
    send(2'b10, 48'h1111_2222_3333, 48'hAAAA_0000_0001, 48'h5555_0000_0002, "R3");
    for (int i = 0; i < 6; i++)
      send(2'b01, 48'h1111_2222_3333, 48'h4000_0000_0000 + 48'(i * 48'h0000_0123_4567),
           48'h5555_0000_0002, "R2");

    // R8 and R4: narrow window, words around the bounds
    load(24'h100000, 24'h200000);
    send(2'b01, 48'h0, 48'h0FFF_FFFF_FFFF, 48'h0, "R4");
    send(2'b01, 48'h0, 48'h2000_0000_0001, 48'h0, "R4");
    send(2'b01, 48'h0, 48'h1000_0000_0000, 48'h0, "R5");
    send(2'b01, 48'h0, 48'h2000_0000_0000, 48'h0, "R5");
    send(2'b01, 48'h0, 48'h1800_0000_1234, 48'h0, "R5");
    // R10: clamp in free-run and holdover
    send(2'b00, 48'hF000_0000_0000, 48'h1800_0000_0000, 48'h0, "R10");
    send(2'b10, 48'h1800_0000_0000, 48'h1800_0000_0000, 48'h0000_0000_0005, "R10");
    // R8: bounds loaded mid-stream apply to later updates
    load(24'h300000, 24'h400000);
    send(2'b01, 48'h0, 48'h2000_0000_0000, 48'h0, "R8");
    // R6: lower above upper
    load(24'h800000, 24'h200000);
    send(2'b01, 48'h0, 48'h0000_0000_0000, 48'h0, "R6");
    send(2'b01, 48'h0, 48'hFFFF_FFFF_FFFF, 48'h0, "R6");
    send(2'b01, 48'h0, 48'h5000_0000_0000, 48'h0, "R6");
    send(2'b01, 48'h0, 48'h8000_0000_0000, 48'h0, "R6");
    // R4: all-ones upper reaches full scale with a nonzero lower bound
    load(24'h000001, 24'hFFFFFF);
    send(2'b00, 48'hFFFF_FFFF_FFFF, 48'h0, 48'h0, "R4");
    send(2'b00, 48'h0000_00FF_FFFF, 48'h0, 48'h0, "R4");
    // R4: upper one below all-ones truncates the low bits
    load(24'h000000, 24'hFFFFFE);
    send(2'b10, 48'h0, 48'h0, 48'hFFFF_FFFF_FFFF, "R4");

    for (int k = 0; k < 50 && sb.size() != 0; k++) @(posedge clk);
    check(sb.size() == 0, "R9", "all updates delivered", 48'(sb.size()), '0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule